// File: doc/BRIEF.md
# Address Breakpoint Match Unit

This block compares every instruction fetch and every load or store against a small set of address triggers. Each trigger has a control word and a compare address. A trigger takes part only when its privilege bits allow the current mode and at least one access kind is enabled. An execute trigger fires on an exact fetch address match. A load or store trigger fires when the access kind agrees and the access address falls inside a window of 1, 2, 4 or 8 bytes that starts at the compare address.

The result is registered. One cycle after the valid strobe, the unit reports a hit flag, the index of the lowest-numbered trigger that fired, and a request for a breakpoint exception that carries cause code 3. The pipeline uses this request to suppress the instruction or the access before it takes effect. The unit never enters a halted debug state.

Top module: `bkpt_match_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `hit_o`, `excp_req_o`, `hit_idx_o` and `excp_cause_o` are all zero.
- R2: A trigger never fires unless its control word has at least one privilege bit set (bit 3 user, bit 4 supervisor, bit 6 machine) and at least one access-kind bit set (bit 0 load, bit 1 store, bit 2 execute).
- R3: An execute match needs control bit 2 set, `fetch_valid_i` high, and `fetch_pc_i` exactly equal to the trigger's compare address. A fetch one byte away does not match.
- R4: A data match needs `mem_valid_i` high together with either control bit 0 set and `mem_read_i` high, or control bit 1 set and `mem_write_i` high. A kind the trigger does not enable never matches.
- R5: The privilege check uses control bit 3 when `priv_i`=0, bit 4 when `priv_i`=1, and bit 6 when `priv_i`=3. When `priv_i`=2, no trigger fires.
- R6: Control bits [17:16] select the data window size: 1 selects 1 byte, 2 selects 2 bytes, 3 selects 4 bytes, and 0 selects 8 bytes. The address matches when compare <= addr < compare + size, computed without wrap-around.
- R7: When several triggers fire in the same cycle, `hit_idx_o` reports the lowest index.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A cycle with neither valid strobe high gives no hit in the next cycle.
- R9: `excp_req_o` equals `hit_o`. `excp_cause_o` is 3 during a hit and 0 otherwise, and `hit_idx_o` is 0 when there is no hit.
- R10: With both valid strobes low, no trigger fires, whatever the trigger settings and addresses are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_ctrl_i | input | NUM_TRIG*XLEN | Control words; trigger k is slice k |
| trig_cmp_i | input | NUM_TRIG*XLEN | Compare addresses; trigger k is slice k |
| priv_i | input | 2 | Current privilege mode |
| fetch_valid_i | input | 1 | Fetch address is valid |
| fetch_pc_i | input | XLEN | Fetch address |
| mem_valid_i | input | 1 | Data access is valid |
| mem_addr_i | input | XLEN | Data access address |
| mem_read_i | input | 1 | Data access is a read |
| mem_write_i | input | 1 | Data access is a write |
| hit_o | output | 1 | A trigger fired on the previous cycle's inputs |
| hit_idx_o | output | IDXW | Index of the reporting trigger |
| excp_req_o | output | 1 | Request a breakpoint exception before the access |
| excp_cause_o | output | 4 | Exception cause code |

## Verification
Suppose a comparator has the wrong privilege bit or the wrong window bound. Then, one cycle after the offending strobe, `hit_o` is wrong for exactly that access, and only at the privilege mode or window edge involved. For that reason the bench drives addresses at the last byte in the window and at the first byte beyond it. A priority fault shows up only when two triggers fire together, as a wrong `hit_idx_o`. A stale output register shows up as a hit that persists into an idle cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int CB_LOAD  = 0;
  localparam int CB_STORE = 1;
  localparam int CB_EXEC  = 2;
  localparam int CB_USER  = 3;
  localparam int CB_SUPV  = 4;
  localparam int CB_MACH  = 6;
  localparam int CB_SIZE  = 16;
  localparam logic [3:0] CAUSE_BREAK = 4'd3;

  // window size in bytes from the two-bit size field (0 means 8 bytes)
  function automatic logic [3:0] win_bytes(input logic [1:0] sz);
    case (sz)
      2'd1:    win_bytes = 4'd1;
      2'd2:    win_bytes = 4'd2;
      2'd3:    win_bytes = 4'd4;
      default: win_bytes = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_trig_cmp.sv
module bkpt_trig_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] ctrl_i,
  input  logic [XLEN-1:0] cmp_i,
  input  logic [1:0]      priv_i,
  input  logic            fetch_valid_i,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic            mem_valid_i,
  input  logic [XLEN-1:0] mem_addr_i,
  input  logic            mem_read_i,
  input  logic            mem_write_i,
  output logic            match_o
);
  import bkpt_pkg::*;

  logic            mode_any, kind_any, priv_ok;
  logic            exec_hit, kind_ok, in_win, mem_hit;
  logic [XLEN:0]   lo_ext, hi_ext, addr_ext;

  assign mode_any = ctrl_i[CB_USER] | ctrl_i[CB_SUPV] | ctrl_i[CB_MACH];
  assign kind_any = ctrl_i[CB_LOAD] | ctrl_i[CB_STORE] | ctrl_i[CB_EXEC];

  always_comb begin
    case (priv_i)
      2'd0:    priv_ok = ctrl_i[CB_USER];
      2'd1:    priv_ok = ctrl_i[CB_SUPV];
      2'd3:    priv_ok = ctrl_i[CB_MACH];
      default: priv_ok = 1'b0;
    endcase
  end

  assign exec_hit = fetch_valid_i & ctrl_i[CB_EXEC] & (fetch_pc_i == cmp_i);

  // window bounds carry one extra bit so the top of memory does not wrap
  assign lo_ext   = {1'b0, cmp_i};
  assign hi_ext   = lo_ext + (XLEN+1)'(win_bytes(ctrl_i[CB_SIZE+1:CB_SIZE]));
  assign addr_ext = {1'b0, mem_addr_i};
  assign in_win   = (addr_ext >= lo_ext) && (addr_ext < hi_ext);

  assign kind_ok = (ctrl_i[CB_LOAD] & mem_read_i) | (ctrl_i[CB_STORE] & mem_write_i);
  assign mem_hit = mem_valid_i & kind_ok & in_win;

  assign match_o = mode_any & kind_any & priv_ok & (exec_hit | mem_hit);
endmodule

// File: rtl/bkpt_prio_enc.sv
module bkpt_prio_enc #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit #(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  localparam int IDXW    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_TRIG*XLEN-1:0] trig_ctrl_i,
  input  logic [NUM_TRIG*XLEN-1:0] trig_cmp_i,
  input  logic [1:0]               priv_i,
  input  logic                     fetch_valid_i,
  input  logic [XLEN-1:0]          fetch_pc_i,
  input  logic                     mem_valid_i,
  input  logic [XLEN-1:0]          mem_addr_i,
  input  logic                     mem_read_i,
  input  logic                     mem_write_i,
  output logic                     hit_o,
  output logic [IDXW-1:0]          hit_idx_o,
  output logic                     excp_req_o,
  output logic [3:0]               excp_cause_o
);
  import bkpt_pkg::*;

  logic [NUM_TRIG-1:0] req;
  logic                any_hit;
  logic [IDXW-1:0]     win_idx;
  logic                hit_q;
  logic [IDXW-1:0]     idx_q;
  logic [3:0]          cause_q;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    bkpt_trig_cmp #(.XLEN(XLEN)) u_cmp (
      .ctrl_i        (trig_ctrl_i[g*XLEN +: XLEN]),
      .cmp_i         (trig_cmp_i[g*XLEN +: XLEN]),
      .priv_i        (priv_i),
      .fetch_valid_i (fetch_valid_i),
      .fetch_pc_i    (fetch_pc_i),
      .mem_valid_i   (mem_valid_i),
      .mem_addr_i    (mem_addr_i),
      .mem_read_i    (mem_read_i),
      .mem_write_i   (mem_write_i),
      .match_o       (req[g])
    );
  end

  bkpt_prio_enc #(.N(NUM_TRIG)) u_prio (
    .req_i (req),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      idx_q   <= '0;
      cause_q <= 4'd0;
    end else begin
      hit_q   <= any_hit;
      idx_q   <= any_hit ? win_idx : '0;
      cause_q <= any_hit ? CAUSE_BREAK : 4'd0;
    end
  end

  assign hit_o        = hit_q;
  assign hit_idx_o    = idx_q;
  assign excp_req_o   = hit_q;
  assign excp_cause_o = cause_q;

  assert_grant_valid_R7: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> req[win_idx]);
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> ((req & ((NUM_TRIG'(1) << win_idx) - NUM_TRIG'(1))) == '0));
  assert_idle_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid_i && !mem_valid_i) |=> !hit_o);
  assert_priv2_never_R5: assert property (@(posedge clk) disable iff (rst)
    (priv_i == 2'd2) |=> !hit_o);
  assert_cause_code_R9: assert property (@(posedge clk) disable iff (rst)
    excp_cause_o == (hit_o ? CAUSE_BREAK : 4'd0));
  assert_any_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> hit_o);
endmodule

// File: tb/bkpt_match_unit_tb_top.sv
`timescale 1ns/1ps
module bkpt_match_unit_tb_top;
  localparam int NT = 4;
  localparam int XL = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [XL-1:0] ctrl [NT];
  logic [XL-1:0] cmpv [NT];
  logic [NT*XL-1:0] ctrl_f, cmp_f;
  logic [1:0] priv = 2'd3;
  logic fv = 1'b0, mv = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [XL-1:0] pc = '0, addr = '0;
  logic hit, ereq;
  logic [1:0] idx;
  logic [3:0] cause;
  int n_run = 0, n_fail = 0;

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      ctrl_f[k*XL +: XL] = ctrl[k];
      cmp_f[k*XL +: XL]  = cmpv[k];
    end
  end

  bkpt_match_unit #(.NUM_TRIG(NT), .XLEN(XL)) dut_i (
    .clk(clk), .rst(rst), .trig_ctrl_i(ctrl_f), .trig_cmp_i(cmp_f),
    .priv_i(priv), .fetch_valid_i(fv), .fetch_pc_i(pc), .mem_valid_i(mv),
    .mem_addr_i(addr), .mem_read_i(rd), .mem_write_i(wr),
    .hit_o(hit), .hit_idx_o(idx), .excp_req_o(ereq), .excp_cause_o(cause));

  function automatic logic [XL-1:0] mk(bit ld, bit st, bit ex, bit u, bit s, bit m, logic [1:0] sz);
    logic [XL-1:0] c = '0;
    c[0] = ld; c[1] = st; c[2] = ex; c[3] = u; c[4] = s; c[6] = m; c[17:16] = sz;
    return c;
  endfunction

  function automatic bit model_trig(int k);
    logic [XL-1:0] c = ctrl[k];
    bit pok, armed, ex, dm;
    longint unsigned w, lo, a;
    pok = (priv == 0) ? c[3] : (priv == 1) ? c[4] : (priv == 3) ? c[6] : 1'b0;
    armed = (c[3] | c[4] | c[6]) & (c[0] | c[1] | c[2]);
    w = (c[17:16] == 2'd1) ? 1 : (c[17:16] == 2'd2) ? 2 : (c[17:16] == 2'd3) ? 4 : 8;
    lo = longint'(cmpv[k]); a = longint'(addr);
    ex = fv & c[2] & (pc == cmpv[k]);
    dm = mv & ((c[0] & rd) | (c[1] & wr)) & (a >= lo) & (a < lo + w);
    return armed & pok & (ex | dm);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // inputs already driven; wait one edge and compare with model and with a literal
  task automatic run_vec(string tag, int exp_hit);
    int eh = 0, ei = 0;
    for (int k = NT - 1; k >= 0; k--) if (model_trig(k)) begin eh = 1; ei = k; end
    @(negedge clk);
    if (exp_hit >= 0) chk({tag, " literal hit"}, hit, exp_hit);
    chk({tag, " hit"}, hit, eh);
    chk({tag, " idx"}, idx, ei);
    chk({tag, " R9 req"}, ereq, eh);
    chk({tag, " R9 cause"}, cause, eh ? 3 : 0);
  endtask

  task automatic clear_trigs();
    for (int k = 0; k < NT; k++) begin ctrl[k] = '0; cmpv[k] = '0; end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_trigs();
    ctrl[0] = mk(1,1,1,1,1,1,0); cmpv[0] = 32'h100;
    fv = 1'b1; pc = 32'h100;
    repeat (2) @(negedge clk);
    chk("R1 reset hit", hit, 0); chk("R1 reset idx", idx, 0);
    chk("R1 reset cause", cause, 0); chk("R1 reset req", ereq, 0);
    fv = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset hit", hit, 0);

    // R2: privilege bits but no kind bits / kind bits but no privilege bits
    clear_trigs(); priv = 2'd3;
    ctrl[0] = mk(0,0,0,1,1,1,0); cmpv[0] = 32'h200; fv = 1; pc = 32'h200;
    run_vec("R2 no kind", 0);
    ctrl[0] = mk(1,1,1,0,0,0,0);
    run_vec("R2 no priv", 0);
    // R3 exec exact
    ctrl[0] = mk(0,0,1,0,0,1,0);
    run_vec("R3 exec exact", 1);
    pc = 32'h201;
    run_vec("R3 exec off by one", 0);
    fv = 0;
    // R4 kind agreement
    ctrl[1] = mk(1,0,0,0,0,1,1); cmpv[1] = 32'h300; mv = 1; addr = 32'h300; wr = 1; rd = 0;
    run_vec("R4 write vs load trig", 0);
    wr = 0; rd = 1;
    run_vec("R4 load match", 1);
    ctrl[1] = mk(0,1,0,0,0,1,1); rd = 0; wr = 1;
    run_vec("R4 store match", 1);
    // R5 privilege mapping
    ctrl[1] = mk(0,1,0,1,0,0,1); priv = 0;
    run_vec("R5 user bit3", 1);
    priv = 1;
    run_vec("R5 user trig in sup", 0);
    ctrl[1] = mk(0,1,0,0,1,0,1);
    run_vec("R5 sup bit4", 1);
    ctrl[1] = mk(0,1,0,1,1,1,1) | 32'h20; priv = 2;
    run_vec("R5 priv2 none", 0);
    priv = 3;
    // R6 window edges
    ctrl[1] = mk(0,1,0,0,0,1,2'd3); addr = 32'h303;
    run_vec("R6 4B last", 1);
    addr = 32'h304;
    run_vec("R6 4B beyond", 0);
    ctrl[1] = mk(0,1,0,0,0,1,2'd0); addr = 32'h307;
    run_vec("R6 8B last", 1);
    addr = 32'h308;
    run_vec("R6 8B beyond", 0);
    ctrl[1] = mk(0,1,0,0,0,1,2'd2); addr = 32'h301;
    run_vec("R6 2B last", 1);
    ctrl[1] = mk(0,1,0,0,0,1,2'd1);
    run_vec("R6 1B beyond", 0);
    addr = 32'h2FF;
    run_vec("R6 below base", 0);
    cmpv[1] = 32'hFFFF_FFFE; ctrl[1] = mk(0,1,0,0,0,1,2'd0); addr = 32'h0;
    run_vec("R6 no wrap", 0);
    addr = 32'hFFFF_FFFF;
    run_vec("R6 top byte", 1);
    // R7 priority
    ctrl[2] = mk(0,1,0,0,0,1,0); cmpv[2] = 32'hFFFF_FFF8; ctrl[3] = ctrl[2]; cmpv[3] = 32'hFFFF_FFFC;
    ctrl[1] = '0;
    run_vec("R7 low wins", 1);
    chk("R7 idx two", idx, 2);
    // R8 / R10 idle clears
    mv = 0; fv = 0;
    run_vec("R10 idle", 0);
    chk("R8 cleared", hit, 0);

    // random
    for (int it = 0; it < 3000; it++) begin
      for (int k = 0; k < NT; k++) begin
        ctrl[k] = mk($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                     $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                     2'($urandom_range(0,3)));
        cmpv[k] = 32'h1000 + $urandom_range(0,15);
      end
      priv = 2'($urandom_range(0,3));
      fv = ($urandom_range(0,2) != 0); pc = 32'h1000 + $urandom_range(0,23);
      mv = ($urandom_range(0,2) != 0); addr = 32'h1000 + $urandom_range(0,23);
      rd = $urandom_range(0,1); wr = $urandom_range(0,1);
      run_vec("R2 R3 R4 R5 R6 R7 R8 random", -1);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule